// File: doc/BRIEF.md
# Sixteen-Pin Blinking Selector Expander

This block is a serial-bus target that controls sixteen open-drain pins. It answers on a two-wire serial bus (SCL clock, SDA data, both open-drain) at a fixed 7-bit device address. A write transaction carries a register pointer byte and then data bytes. A read transaction returns the register that the last pointer byte selected. The pointer does not advance, so every data byte of one transaction goes to the same register.

Each pin has a 2-bit selector. The selector drives the pin low, releases it so that an external pull-up takes it high, or makes it follow one of two blink channels. Each blink channel has a period register and a duty register. A fixed tick, taken from the system clock through a parameterised divider, clocks both channels. Two read-only input registers report the levels actually seen on the pins. A pin that is wired to another pin therefore reads low when that other pin is driven low.

Register indices: 0 = pin levels 7..0, 1 = pin levels 15..8, 2 = period0, 3 = duty0, 4 = period1, 5 = duty1, 6..9 = selector registers sel0..sel3.

Top module: `ledsel16`

## Requirements
- R1: The target acknowledges only its own 7-bit address (parameter DEV_ADDR, sent in bits 7..1 of the first byte, with bit 0 = 1 for read). Any other address gets no acknowledge, and the transaction changes no register.
- R2: In a write transaction, the byte after the address loads the pointer. Every further byte is written to the register at that pointer, with no increment, so the last byte written is the one that stays.
- R3: A read transaction returns, most significant bit first, the register at the pointer set by the previous write transaction.
- R4: After reset, period0 and period1 hold 0xFF, duty0 and duty1 hold 0x80, and sel0..sel3 hold 0x55. All pins are released and SDA is released.
- R5: Pin n is controlled by the field at bits 2(n mod 4)+1 .. 2(n mod 4) of selector register 6+n/4. Code 00 drives the pin low one clock later and code 01 releases it. Code 10 makes the pin follow blink channel 0 and code 11 makes it follow blink channel 1.
- R6: Register 0 bit k reports the level of pin k. Register 1 bit k reports the level of pin 8+k. The levels are taken from the pin inputs through a two-flop synchroniser, so a released pin that an external wire pulls low reads 0.
- R7: Writes to registers 0 and 1, and writes to pointers 10 to 255, change nothing. Reads at pointers 10 to 255 return 0x00.
- R8: Blink channel c has a period of (period_c+1) ticks, with one tick every TICK_DIV clocks. It is low during tick counts t of each period that satisfy t*256 < duty_c*(period_c+1). Duty 0x00 therefore never drives low, and duty 0xFF with period 3 always drives low.
- R9: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial bus clock level |
| sda_i | input | 1 | Serial bus data level (wired value) |
| sda_drive_low | output | 1 | 1 = pull SDA low |
| pin_level_i | input | 16 | Level seen on each pin |
| pin_drive_low | output | 16 | 1 = pull the pin low |

## Verification
The assertions take for granted that SCL and SDA are slow compared with the system clock. Each SCL low or high phase must last at least four clocks. SDA may change while SCL is high only to form a start or stop, and never while the target holds an acknowledge or a data bit. The bench master meets these rules by changing SDA four clocks after each SCL fall and holding SCL high for eight clocks. Its open-drain pin model ties pins 0..4 to pins 5..9, so the read-back values depend on the real pin levels and not on the selector registers.

// File: rtl/ledsel_pkg.sv
package ledsel_pkg;
  localparam int PIN_COUNT = 16;
  localparam int CHANNELS  = 2;
  localparam int BYTE_W    = 8;
  localparam int IN_REGS   = PIN_COUNT / BYTE_W;
  localparam int SEL_REGS  = PIN_COUNT / 4;
  localparam int FIRST_CH  = IN_REGS;
  localparam int FIRST_SEL = IN_REGS + 2 * CHANNELS;
  localparam int NUM_REGS  = FIRST_SEL + SEL_REGS;

  localparam logic [1:0] SEL_LOW  = 2'b00;
  localparam logic [1:0] SEL_OPEN = 2'b01;
  localparam logic [1:0] SEL_CH0  = 2'b10;
  localparam logic [1:0] SEL_CH1  = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } tgt_state_e;

  function automatic logic [BYTE_W-1:0] reg_reset_val(input int idx);
    if (idx >= FIRST_SEL && idx < NUM_REGS) return 8'h55;
    if (idx >= FIRST_CH && idx < FIRST_SEL) return ((idx - FIRST_CH) % 2 == 0) ? 8'hFF : 8'h80;
    return 8'h00;
  endfunction
endpackage

// File: rtl/ledsel_i2c_tgt.sv
module ledsel_i2c_tgt import ledsel_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  input  logic [BYTE_W-1:0] rd_data_i
);
  logic [1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  tgt_state_e state;
  logic [2:0] bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic byte_full, rnw;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11; sda_ff <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s    = scl_ff[1];
  assign sda_s    = sda_ff[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk) begin
    wr_en_o <= 1'b0;
    if (rst) begin
      state <= ST_IDLE; bit_cnt <= '0; shreg <= '0; byte_full <= 1'b0;
      rnw <= 1'b0; sda_low_o <= 1'b0; ptr_o <= '0; wr_data_o <= '0;
    end else if (start_c) begin
      state <= ST_ADDR; bit_cnt <= '0; byte_full <= 1'b0; sda_low_o <= 1'b0;
    end else if (stop_c) begin
      state <= ST_IDLE; sda_low_o <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        ST_ADDR, ST_PTR, ST_WR: begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) byte_full <= 1'b1;
        end
        ST_RD: begin
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) byte_full <= 1'b1;
        end
        ST_RD_ACK: if (sda_s) state <= ST_IDLE;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        ST_ADDR: if (byte_full) begin
          byte_full <= 1'b0;
          if (shreg[7:1] == DEV_ADDR) begin
            state <= ST_ADDR_ACK; sda_low_o <= 1'b1; rnw <= shreg[0];
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ADDR_ACK: begin
          bit_cnt <= '0;
          if (rnw) begin
            state <= ST_RD; shreg <= rd_data_i; sda_low_o <= ~rd_data_i[7];
          end else begin
            state <= ST_PTR; sda_low_o <= 1'b0;
          end
        end
        ST_PTR: if (byte_full) begin
          byte_full <= 1'b0; ptr_o <= shreg; state <= ST_PTR_ACK; sda_low_o <= 1'b1;
        end
        ST_PTR_ACK, ST_WR_ACK: begin
          state <= ST_WR; sda_low_o <= 1'b0; bit_cnt <= '0;
        end
        ST_WR: if (byte_full) begin
          byte_full <= 1'b0; wr_data_o <= shreg; wr_en_o <= 1'b1;
          state <= ST_WR_ACK; sda_low_o <= 1'b1;
        end
        ST_RD: begin
          if (byte_full) begin
            byte_full <= 1'b0; state <= ST_RD_ACK; sda_low_o <= 1'b0;
          end else begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0}; sda_low_o <= ~shreg[6];
          end
        end
        ST_RD_ACK: begin
          state <= ST_RD; shreg <= rd_data_i; sda_low_o <= ~rd_data_i[7]; bit_cnt <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ledsel_blink.sv
module ledsel_blink import ledsel_pkg::*; #(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  output logic         low_o
);
  localparam int PW = 2 * W + 1;
  logic [W-1:0]  cnt;
  logic [PW-1:0] thr, pos;

  assign thr = PW'(duty) * (PW'(period) + PW'(1));
  assign pos = PW'({cnt, W'(0)});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; low_o <= 1'b0;
    end else begin
      if (tick) cnt <= (cnt >= period) ? '0 : cnt + W'(1);
      low_o <= (pos < thr);
    end
  end
endmodule

// File: rtl/ledsel_pinmux.sv
module ledsel_pinmux import ledsel_pkg::*; #(
  parameter int PINS = PIN_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*PINS-1:0] sel_flat,
  input  logic [CHANNELS-1:0] blink_low,
  output logic [PINS-1:0]   drv_low_o
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) drv_low_o[n] <= 1'b0;
      else begin
        case (sel_flat[2*n +: 2])
          SEL_LOW:  drv_low_o[n] <= 1'b1;
          SEL_OPEN: drv_low_o[n] <= 1'b0;
          SEL_CH0:  drv_low_o[n] <= blink_low[0];
          default:  drv_low_o[n] <= blink_low[1];
        endcase
      end
    end
  end
endmodule

// File: rtl/ledsel16.sv
module ledsel16 import ledsel_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h63,
  parameter int         TICK_DIV = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_drive_low,
  input  logic [PIN_COUNT-1:0] pin_level_i,
  output logic [PIN_COUNT-1:0] pin_drive_low
);
  localparam int IW    = $clog2(NUM_REGS);
  localparam int DEPTH = 1 << IW;
  localparam int TW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic                   wr_en;
  logic [BYTE_W-1:0]      ptr, wr_data, rd_data;
  logic [BYTE_W-1:0]      cfg_q  [DEPTH];
  logic [BYTE_W-1:0]      rd_arr [DEPTH];
  logic [PIN_COUNT-1:0]   pin_m, pin_s;
  logic [2*PIN_COUNT-1:0] sel_flat;
  logic [CHANNELS-1:0]    blink_low;
  logic [TW-1:0]          tick_cnt;
  logic                   tick;

  ledsel_i2c_tgt #(.DEV_ADDR(DEV_ADDR)) u_tgt (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_low_o(sda_drive_low),
    .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data), .rd_data_i(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cfg_q[i] <= reg_reset_val(i);
    end else if (wr_en && ptr >= BYTE_W'(FIRST_CH) && ptr < BYTE_W'(NUM_REGS)) begin
      cfg_q[ptr[IW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_m <= '1; pin_s <= '1;
    end else begin
      pin_m <= pin_level_i; pin_s <= pin_m;
    end
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_rd
    if (r < IN_REGS) begin : g_in
      assign rd_arr[r] = pin_s[r*BYTE_W +: BYTE_W];
    end else if (r < NUM_REGS) begin : g_cfg
      assign rd_arr[r] = cfg_q[r];
    end else begin : g_none
      assign rd_arr[r] = '0;
    end
  end

  assign rd_data = (ptr < BYTE_W'(DEPTH)) ? rd_arr[ptr[IW-1:0]] : '0;

  for (genvar s = 0; s < SEL_REGS; s++) begin : g_sel
    assign sel_flat[s*BYTE_W +: BYTE_W] = cfg_q[FIRST_SEL+s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0; tick <= 1'b0;
    end else begin
      tick     <= (tick_cnt == TW'(TICK_DIV-1));
      tick_cnt <= (tick_cnt == TW'(TICK_DIV-1)) ? '0 : tick_cnt + TW'(1);
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    ledsel_blink #(.W(BYTE_W)) u_blink (
      .clk(clk), .rst(rst), .tick(tick),
      .period(cfg_q[FIRST_CH+2*c]), .duty(cfg_q[FIRST_CH+2*c+1]),
      .low_o(blink_low[c])
    );
  end

  ledsel_pinmux #(.PINS(PIN_COUNT)) u_mux (
    .clk(clk), .rst(rst), .sel_flat(sel_flat), .blink_low(blink_low),
    .drv_low_o(pin_drive_low)
  );
endmodule

// File: rtl/ledsel16_chk.sv
module ledsel16_chk import ledsel_pkg::*; (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_i,
  input logic                   sda_low,
  input logic [PIN_COUNT-1:0]   pin_drv_low,
  input logic [2*PIN_COUNT-1:0] sel_flat,
  input logic                   wr_en,
  input logic [BYTE_W-1:0]      ptr
);
  // R4
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_drv_low == '0 && !sda_low));

  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin_chk
    // R5
    sel_low_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[2*n +: 2] == SEL_LOW) |=> pin_drv_low[n]);
    // R5
    sel_open_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[2*n +: 2] == SEL_OPEN) |=> !pin_drv_low[n]);
  end

  // R7
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (ptr >= BYTE_W'(NUM_REGS) || ptr < BYTE_W'(IN_REGS))) |=> $stable(sel_flat));

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low) |-> !scl_i);
endmodule

bind ledsel16 ledsel16_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_low(sda_drive_low),
  .pin_drv_low(pin_drive_low), .sel_flat(sel_flat), .wr_en(wr_en), .ptr(ptr)
);

// File: tb/ledsel16_bench.sv
module ledsel16_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] ADDR = 7'h63;
  localparam int TDIV = 4;
  localparam int Q = 4;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_drive_low, sda_bus;
  logic [15:0] pin_drive_low, pin_level;
  int checks = 0, errors = 0, sda_viol = 0;
  bit done = 0;
  logic sda_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = m_sda & ~sda_drive_low;
  // pins 0..4 are wired to pins 5..9
  assign pin_level = ~(pin_drive_low | {6'b0, pin_drive_low[4:0], pin_drive_low[9:5]});

  ledsel16 #(.DEV_ADDR(ADDR), .TICK_DIV(TDIV)) u_ledsel16 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_drive_low(sda_drive_low),
    .pin_level_i(pin_level), .pin_drive_low(pin_drive_low)
  );

  // R9 monitor: SDA drive must not change while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_drive_low !== sda_prev && m_scl) sda_viol++;
    sda_prev = sda_drive_low;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_clk(Q);
    m_scl = 1'b1; wait_clk(H);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(H/2);
    b = sda_bus; wait_clk(H/2);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic bit_v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(bit_v);
    ack = !bit_v;
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic bit_v;
    for (int i = 7; i >= 0; i--) begin recv_bit(bit_v); b[i] = bit_v; end
    send_bit(1'b1);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] p, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, output logic ack_a);
    logic ack;
    bus_start();
    write_byte({a, 1'b0}, ack_a);
    write_byte(p, ack);
    write_byte(d0, ack);
    if (n > 1) write_byte(d1, ack);
    bus_stop();
  endtask

  task automatic wr(input logic [7:0] p, input logic [7:0] d);
    logic ack;
    reg_write(ADDR, p, 1, d, 8'h00, ack);
  endtask

  task automatic rd(input logic [7:0] p, output logic [7:0] v);
    logic ack;
    bus_start(); write_byte({ADDR, 1'b0}, ack); write_byte(p, ack); bus_stop();
    bus_start(); write_byte({ADDR, 1'b1}, ack); read_byte(v); bus_stop();
  endtask

  task automatic read_pins(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(8'd0, lo); rd(8'd1, hi);
    v = {hi, lo};
  endtask

  task automatic count_low(input int pin, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_drive_low[pin]) c++;
    end
  endtask

  // pin number, expected pin levels after driving it low (pins 0..4 tied to 5..9)
  localparam logic [19:0] PIN_VEC [5] = '{
    {4'd0, 16'hFFDE}, {4'd1, 16'hFF9C}, {4'd2, 16'hFF18}, {4'd3, 16'hFE10}, {4'd4, 16'hFC00}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v8;
    logic [15:0] v16;
    logic ack;
    int c;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R4 reset state
    check("R4 pins released", {16'h0, pin_drive_low}, 32'h0);
    check("R4 sda released", {31'h0, sda_drive_low}, 32'h0);
    rd(8'd2, v8); check("R4 period0", {24'h0, v8}, 32'hFF);
    rd(8'd3, v8); check("R4 duty0", {24'h0, v8}, 32'h80);
    rd(8'd9, v8); check("R4 sel3", {24'h0, v8}, 32'h55);
    read_pins(v16); check("R6 all released", {16'h0, v16}, 32'hFFFF);

    // R5 and R6: drive pins 0..4 low one at a time, read real levels
    for (int i = 0; i < 5; i++) begin
      int pin;
      logic [7:0] p;
      pin = int'(PIN_VEC[i][19:16]);
      p = 8'(6 + pin / 4);
      rd(p, v8);
      v8 = v8 & ~(8'h03 << ((pin % 4) * 2));
      wr(p, v8);
      read_pins(v16);
      check("R5 R6 tied pin levels", {16'h0, v16}, {16'h0, PIN_VEC[i][15:0]});
    end

    // R1 foreign address: no acknowledge, no change
    reg_write(7'h25, 8'd6, 1, 8'hFF, 8'h00, ack);
    check("R1 foreign address nack", {31'h0, ack}, 32'h0);
    rd(8'd6, v8); check("R1 sel0 unchanged", {24'h0, v8}, 32'h00);
    rd(8'd7, v8); check("R3 sel1 readback", {24'h0, v8}, 32'h54);

    // release everything again
    for (int s = 6; s < 10; s++) wr(8'(s), 8'h55);
    read_pins(v16); check("R6 released again", {16'h0, v16}, 32'hFFFF);

    // R7 read-only and out-of-range pointers
    wr(8'd0, 8'h00);
    rd(8'd0, v8); check("R7 input reg read-only", {24'h0, v8}, 32'hFF);
    wr(8'd12, 8'h77);
    rd(8'd12, v8); check("R7 out-of-range reads zero", {24'h0, v8}, 32'h00);
    rd(8'd200, v8); check("R7 high pointer reads zero", {24'h0, v8}, 32'h00);

    // R2 two data bytes to one pointer: last one stays
    reg_write(ADDR, 8'd5, 2, 8'h11, 8'h40, ack);
    rd(8'd5, v8); check("R2 no auto increment", {24'h0, v8}, 32'h40);
    rd(8'd4, v8); check("R2 neighbour untouched", {24'h0, v8}, 32'hFF);

    // R8 blink channels; sel3 = 0xE4 -> pin12 low, pin13 open, pin14 ch0, pin15 ch1
    wr(8'd2, 8'd3); wr(8'd3, 8'h80); wr(8'd4, 8'd7);
    wr(8'd9, 8'hE4);
    wait_clk(100);
    count_low(12, 128, c); check("R5 code 00 steady low", c, 128);
    count_low(13, 128, c); check("R5 code 01 steady released", c, 0);
    count_low(14, 128, c); check("R8 ch0 half duty", c, 64);
    count_low(15, 128, c); check("R8 ch1 quarter duty", c, 32);
    wr(8'd3, 8'h00); wait_clk(40);
    count_low(14, 128, c); check("R8 duty zero never low", c, 0);
    wr(8'd3, 8'hFF); wait_clk(40);
    count_low(14, 128, c); check("R8 duty ff always low", c, 128);

    check("R9 sda changes only with scl low", sda_viol, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule